// File: doc/BRIEF.md
# Video sync timing generator

This block produces the pixel, line and field timing for a video encoder. It holds a pixel counter and a line counter, both with programmable totals, and a field flag. In master mode the counters run free. Horizontal, vertical and frame sync outputs are decoded from them with programmable widths and polarities, and the block enables all three sync pin drivers.

In slave mode the counters lock to outside timing. One source is three sync pins whose active polarity is programmable. Each pin's inactive-to-active transition loads a counter with a programmable offset. The other source is the timing reference codes embedded in an 8-bit BT.656 byte stream. Two control bits let the frame sync pin alone supply the horizontal phase, the vertical phase, or both. When it supplies both, the horizontal and vertical pins are released for output use. When no event arrives, the counters keep running free. Frame sync is therefore optional for progressive input.

Top module: `vsync_timing_gen`

## Requirements
- R1: While `rst_n` is low, `pix_cnt`, `line_cnt` and `field_id` are 0.
- R2: With no load event, each clock edge adds one to `pix_cnt`. On the edge after `pix_cnt` reaches `cfg_pix_last` (or above), `pix_cnt` goes to 0 and `line_cnt` advances. `line_cnt` advances to 0 when it is at `cfg_line_last` or above, and otherwise by one. This holds in every mode, so missing sync inputs leave the counters free-running.
- R3: Sync output levels follow `pix_cnt` and `line_cnt`. `hs_o` is active while `pix_cnt < cfg_hs_width`. `vs_o` is active while `line_cnt < cfg_vs_width`. `fs_o` is active while `line_cnt < cfg_vs_width` and `field_id` is 0. A polarity bit of 1 means active high and 0 means active low. In master mode (`cfg_mode` 0), `field_id` inverts each time `line_cnt` wraps to 0.
- R4: In master mode, `hs_i`, `vs_i`, `fs_i` and `vid_data` have no effect on the counters or on `field_id`.
- R5: In sync-pin slave mode (`cfg_mode` 1, and also 3), suppose `hs_i` is first sampled at its active level on edge k. After edge k+1, `pix_cnt` equals `cfg_h_offset` and `line_cnt` has advanced by one at that edge. Holding the active level, or returning to the inactive level, loads nothing.
- R6: In sync-pin slave mode, an inactive-to-active transition of `vs_i` loads `line_cnt` with `cfg_v_offset`, with the same timing as R5. `pix_cnt` is not disturbed.
- R7: Setting `cfg_h_from_fs` makes the `fs_i` transition the pixel load source in place of `hs_i`, which is then ignored. Setting `cfg_v_from_fs` does the same for the line load and `vs_i`.
- R8: In sync-pin slave mode, `field_id` equals the active state of `fs_i` that was sampled one edge earlier.
- R9: `hs_oe` and `vs_oe` are 1 in mode 0, in mode 2, and whenever both `cfg_h_from_fs` and `cfg_v_from_fs` are set; otherwise they are 0. `fs_oe` is 1 only in modes 0 and 2.
- R10: In reference-code slave mode (`cfg_mode` 2), a code is the byte sequence FF, 00, 00, XY on consecutive edges. In XY, bit 7 is 1, F is bit 6, V is bit 5 and H is bit 4. Bits 3..0 equal {V^H, F^H, F^V, F^V^H}. A valid code with H=1 that is sampled on edge k sets `pix_cnt` to `cfg_h_offset` and advances `line_cnt` after edge k+1.
- R11: A code whose bit 7 is 0 or whose bits 3..0 fail the check is ignored. The counters and `field_id` carry on as in R2.
- R12: In mode 2, `field_id` takes the F bit of each valid code, whether H is 0 or 1. A valid code with H=1 and V=0 loads `line_cnt` with `cfg_v_offset` when the previous valid code with H=1 had V=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0 master, 1 sync-pin slave, 2 reference-code slave, 3 as 1 |
| cfg_hpol | input | 1 | Horizontal sync polarity, 1 active high |
| cfg_vpol | input | 1 | Vertical sync polarity, 1 active high |
| cfg_fpol | input | 1 | Frame sync polarity, 1 active high |
| cfg_h_from_fs | input | 1 | Take pixel phase from frame sync |
| cfg_v_from_fs | input | 1 | Take line phase from frame sync |
| cfg_pix_last | input | PIX_W | Last pixel index of a line |
| cfg_line_last | input | LINE_W | Last line index of a field |
| cfg_hs_width | input | PIX_W | Horizontal sync width in pixels |
| cfg_vs_width | input | LINE_W | Vertical sync width in lines |
| cfg_h_offset | input | PIX_W | Pixel value loaded by a horizontal event |
| cfg_v_offset | input | LINE_W | Line value loaded by a vertical event |
| hs_i | input | 1 | Horizontal sync pin, input side |
| vs_i | input | 1 | Vertical sync pin, input side |
| fs_i | input | 1 | Frame sync pin, input side |
| vid_data | input | 8 | BT.656 byte stream |
| hs_o | output | 1 | Horizontal sync pin, output side |
| vs_o | output | 1 | Vertical sync pin, output side |
| fs_o | output | 1 | Frame sync pin, output side |
| hs_oe | output | 1 | Horizontal pin driver enable |
| vs_oe | output | 1 | Vertical pin driver enable |
| fs_oe | output | 1 | Frame pin driver enable |
| pix_cnt | output | PIX_W | Pixel counter |
| line_cnt | output | LINE_W | Line counter |
| field_id | output | 1 | Field flag |

## Verification
The hardest state to reach from the ports is the end of vertical blanking in reference-code mode. It needs two valid codes with H=1 in a row, the first with V=1 and the second with V=0, each with correct protection bits. The bench builds every code from a helper that works out bits 3..0 from F, V and H. It sends the sequence set by vertical blanking, then repeats the V=0 code to show it does not load again. It also sends deliberately corrupted codes and a code with H=0 between the valid ones. In the pin modes, polarities and offsets are drawn at random, so each transition is checked both against active-high and active-low levels.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic [1:0] {
    VTG_MASTER    = 2'd0,
    VTG_SLAVE_PIN = 2'd1,
    VTG_SLAVE_TRC = 2'd2,
    VTG_SLAVE_ALT = 2'd3
  } vtg_mode_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } trc_flags_t;

  // protection nibble of a reference code
  function automatic logic [3:0] trc_protect(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // 1 when lvl is at the active level selected by pol (pol=1 active high)
  function automatic logic pol_apply(input logic lvl, input logic pol);
    return ~(lvl ^ pol);
  endfunction

endpackage

// File: rtl/vtg_trc_decoder.sv
module vtg_trc_decoder
  import vtg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  output logic              code_valid,
  output trc_flags_t        code_flags
);
  localparam logic [DATA_W-1:0] ALL_ONES  = '1;
  localparam logic [DATA_W-1:0] ALL_ZEROS = '0;

  logic [DATA_W-1:0] b1, b2, b3;
  logic hdr_seen, prot_ok;

  assign hdr_seen = (b3 == ALL_ONES) && (b2 == ALL_ZEROS) && (b1 == ALL_ZEROS);
  assign prot_ok  = din[DATA_W-1] &&
                    (din[3:0] == trc_protect(din[DATA_W-2], din[DATA_W-3], din[DATA_W-4]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b1 <= '0;
      b2 <= '0;
      b3 <= '0;
      code_valid <= 1'b0;
      code_flags <= '0;
    end else begin
      b3 <= b2;
      b2 <= b1;
      b1 <= din;
      code_valid <= hdr_seen && prot_ok;
      if (hdr_seen && prot_ok)
        code_flags <= {din[DATA_W-2], din[DATA_W-3], din[DATA_W-4]};
    end
  end

  // R10
  hdr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> ($past(b3) == ALL_ONES && $past(b2) == ALL_ZEROS && $past(b1) == ALL_ZEROS));

endmodule

// File: rtl/vtg_counters.sv
module vtg_counters #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_last,
  input  logic [PIX_W-1:0]  h_off,
  input  logic [LINE_W-1:0] line_last,
  input  logic [LINE_W-1:0] v_off,
  input  logic              h_load,
  input  logic              v_load,
  input  logic              field_set,
  input  logic              field_val,
  input  logic              toggle_en,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic              field_id
);
  function automatic logic [PIX_W-1:0] pix_next(input logic [PIX_W-1:0] cur,
                                                input logic [PIX_W-1:0] last);
    return (cur >= last) ? '0 : cur + 1'b1;
  endfunction

  function automatic logic [LINE_W-1:0] line_next(input logic [LINE_W-1:0] cur,
                                                  input logic [LINE_W-1:0] last);
    return (cur >= last) ? '0 : cur + 1'b1;
  endfunction

  logic pix_wrap, line_step, line_wrap, field_wrap;

  assign pix_wrap   = pix_cnt >= pix_last;
  assign line_step  = h_load | pix_wrap;
  assign line_wrap  = line_cnt >= line_last;
  assign field_wrap = line_step & line_wrap & ~v_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_cnt  <= '0;
      line_cnt <= '0;
      field_id <= 1'b0;
    end else begin
      pix_cnt <= h_load ? h_off : pix_next(pix_cnt, pix_last);
      if (v_load)
        line_cnt <= v_off;
      else if (line_step)
        line_cnt <= line_next(line_cnt, line_last);
      if (field_set)
        field_id <= field_val;
      else if (toggle_en && field_wrap)
        field_id <= ~field_id;
    end
  end

  // R2
  pix_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_load && !pix_wrap) |=> (pix_cnt == $past(pix_cnt) + 1'b1));

  // R5 R10
  hload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_load |=> (pix_cnt == $past(h_off)));

  // R6 R12
  vload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_load |=> (line_cnt == $past(v_off)));

  // R3
  field_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle_en && $past(toggle_en) && field_id != $past(field_id)) |-> $past(field_wrap));

endmodule

// File: rtl/vsync_timing_gen.sv
module vsync_timing_gen
  import vtg_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_hpol,
  input  logic              cfg_vpol,
  input  logic              cfg_fpol,
  input  logic              cfg_h_from_fs,
  input  logic              cfg_v_from_fs,
  input  logic [PIX_W-1:0]  cfg_pix_last,
  input  logic [LINE_W-1:0] cfg_line_last,
  input  logic [PIX_W-1:0]  cfg_hs_width,
  input  logic [LINE_W-1:0] cfg_vs_width,
  input  logic [PIX_W-1:0]  cfg_h_offset,
  input  logic [LINE_W-1:0] cfg_v_offset,
  input  logic              hs_i,
  input  logic              vs_i,
  input  logic              fs_i,
  input  logic [7:0]        vid_data,
  output logic              hs_o,
  output logic              vs_o,
  output logic              fs_o,
  output logic              hs_oe,
  output logic              vs_oe,
  output logic              fs_oe,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic              field_id
);
  localparam int HS_B = 0;
  localparam int VS_B = 1;
  localparam int FS_B = 2;

  vtg_mode_e mode;
  logic is_master, is_trc, is_pin;
  assign mode      = vtg_mode_e'(cfg_mode);
  assign is_master = (mode == VTG_MASTER);
  assign is_trc    = (mode == VTG_SLAVE_TRC);
  assign is_pin    = !is_master && !is_trc;

  // pin sampler: active levels, then rising-active detection
  logic [2:0] act_now, act_q, act_qq, act_rise;
  assign act_now = {pol_apply(fs_i, cfg_fpol), pol_apply(vs_i, cfg_vpol), pol_apply(hs_i, cfg_hpol)};
  assign act_rise = act_q & ~act_qq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      act_qq <= '0;
    end else begin
      act_q  <= act_now;
      act_qq <= act_q;
    end
  end

  // reference-code path
  logic code_valid, eav_seen, v_prev;
  trc_flags_t code_flags;

  vtg_trc_decoder #(.DATA_W(8)) u_trc (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (vid_data),
    .code_valid (code_valid),
    .code_flags (code_flags)
  );

  assign eav_seen = code_valid & code_flags.h;

  always_ff @(posedge clk) begin
    if (!rst_n)        v_prev <= 1'b0;
    else if (eav_seen) v_prev <= code_flags.v;
  end

  // load event selection
  logic h_load, v_load, field_set, field_val;
  always_comb begin
    h_load = 1'b0;
    v_load = 1'b0;
    field_set = 1'b0;
    field_val = 1'b0;
    if (is_pin) begin
      h_load    = cfg_h_from_fs ? act_rise[FS_B] : act_rise[HS_B];
      v_load    = cfg_v_from_fs ? act_rise[FS_B] : act_rise[VS_B];
      field_set = 1'b1;
      field_val = act_q[FS_B];
    end else if (is_trc) begin
      h_load    = eav_seen;
      v_load    = eav_seen & ~code_flags.v & v_prev;
      field_set = code_valid;
      field_val = code_flags.f;
    end
  end

  vtg_counters #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_last  (cfg_pix_last),
    .h_off     (cfg_h_offset),
    .line_last (cfg_line_last),
    .v_off     (cfg_v_offset),
    .h_load    (h_load),
    .v_load    (v_load),
    .field_set (field_set),
    .field_val (field_val),
    .toggle_en (is_master),
    .pix_cnt   (pix_cnt),
    .line_cnt  (line_cnt),
    .field_id  (field_id)
  );

  // sync decode and pin direction
  logic hs_on, vs_on, fs_on, pins_free;
  assign hs_on = pix_cnt < cfg_hs_width;
  assign vs_on = line_cnt < cfg_vs_width;
  assign fs_on = vs_on & ~field_id;

  assign hs_o = pol_apply(hs_on, cfg_hpol);
  assign vs_o = pol_apply(vs_on, cfg_vpol);
  assign fs_o = pol_apply(fs_on, cfg_fpol);

  assign pins_free = is_master | is_trc | (cfg_h_from_fs & cfg_v_from_fs);
  assign hs_oe = pins_free;
  assign vs_oe = pins_free;
  assign fs_oe = is_master | is_trc;

  // R4
  master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> (!h_load && !v_load && !field_set));

endmodule

// File: tb/vsync_timing_gen_bench.sv
module vsync_timing_gen_bench;
  localparam int PW = 12;
  localparam int LW = 11;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [1:0] cfg_mode;
  logic cfg_hpol, cfg_vpol, cfg_fpol, cfg_h_from_fs, cfg_v_from_fs;
  logic [PW-1:0] cfg_pix_last, cfg_hs_width, cfg_h_offset;
  logic [LW-1:0] cfg_line_last, cfg_vs_width, cfg_v_offset;
  logic hs_i, vs_i, fs_i;
  logic [7:0] vid_data;
  logic hs_o, vs_o, fs_o, hs_oe, vs_oe, fs_oe, field_id;
  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;

  vsync_timing_gen #(.PIX_W(PW), .LINE_W(LW)) u_vsync_timing_gen (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cfg_hpol(cfg_hpol), .cfg_vpol(cfg_vpol), .cfg_fpol(cfg_fpol),
    .cfg_h_from_fs(cfg_h_from_fs), .cfg_v_from_fs(cfg_v_from_fs),
    .cfg_pix_last(cfg_pix_last), .cfg_line_last(cfg_line_last),
    .cfg_hs_width(cfg_hs_width), .cfg_vs_width(cfg_vs_width),
    .cfg_h_offset(cfg_h_offset), .cfg_v_offset(cfg_v_offset),
    .hs_i(hs_i), .vs_i(vs_i), .fs_i(fs_i), .vid_data(vid_data),
    .hs_o(hs_o), .vs_o(vs_o), .fs_o(fs_o),
    .hs_oe(hs_oe), .vs_oe(vs_oe), .fs_oe(fs_oe),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .field_id(field_id)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int P, L, HW, VW, HO, VO;
  int ep, el;

  function automatic int np(int p);
    return (p >= P) ? 0 : p + 1;
  endfunction
  function automatic int lstep(int l);
    return (l >= L) ? 0 : l + 1;
  endfunction
  function automatic int nl(int p, int l);
    return (p >= P) ? lstep(l) : l;
  endfunction
  function automatic int lvl(bit active, bit pol);
    return active ? int'(pol) : int'(!pol);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    step(1);
    el = nl(ep, el);
    ep = np(ep);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      tick();
      chk({tag, " pix"}, int'(pix_cnt), ep);
      chk({tag, " line"}, int'(line_cnt), el);
    end
  endtask

  task automatic apply_cfg(int mode, bit hf, bit vf);
    cfg_mode = 2'(mode);
    cfg_h_from_fs = hf;
    cfg_v_from_fs = vf;
    cfg_pix_last = PW'(P);
    cfg_line_last = LW'(L);
    cfg_hs_width = PW'(HW);
    cfg_vs_width = LW'(VW);
    cfg_h_offset = PW'(HO);
    cfg_v_offset = LW'(VO);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    hs_i = ~cfg_hpol;
    vs_i = ~cfg_vpol;
    fs_i = ~cfg_fpol;
    vid_data = 8'h80;
    step(2);
    chk("R1 pix in reset", int'(pix_cnt), 0);
    chk("R1 line in reset", int'(line_cnt), 0);
    chk("R1 field in reset", int'(field_id), 0);
    rst_n = 1'b1;
    ep = 0;
    el = 0;
  endtask

  // input changed before edge k; checks after edge k+1
  task automatic evt(bit hl, bit vl, string tag);
    int p1;
    step(1);
    vid_data = 8'h80;
    el = nl(ep, el);
    ep = np(ep);
    step(1);
    p1 = ep;
    if (hl) begin
      ep = HO;
      el = vl ? VO : lstep(el);
    end else begin
      el = vl ? VO : nl(p1, el);
      ep = np(p1);
    end
    chk({tag, " pix"}, int'(pix_cnt), ep);
    chk({tag, " line"}, int'(line_cnt), el);
  endtask

  // bad: 0 valid, 1 protection bit flipped, 2 top bit cleared
  task automatic send_code(bit f, bit v, bit h, int bad);
    logic [7:0] xy;
    xy[7] = 1'b1;
    xy[6] = f;
    xy[5] = v;
    xy[4] = h;
    xy[3] = (v != h);
    xy[2] = (f != h);
    xy[1] = (f != v);
    xy[0] = (f + v + h) % 2 == 1;
    if (bad == 1) xy[0] = ~xy[0];
    if (bad == 2) xy[7] = 1'b0;
    vid_data = 8'hFF; tick();
    vid_data = 8'h00; tick();
    vid_data = 8'h00; tick();
    vid_data = xy;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1357);
    rst_n = 1'b0;
    cfg_hpol = 1'b1; cfg_vpol = 1'b1; cfg_fpol = 1'b1;
    P = 9; L = 3; HW = 2; VW = 1; HO = 0; VO = 0;
    apply_cfg(0, 1'b0, 1'b0);
    hs_i = 1'b0; vs_i = 1'b0; fs_i = 1'b0; vid_data = 8'h80;
    step(1);

    // master mode, random configuration and random junk on the inputs
    for (int it = 0; it < 3; it++) begin
      int cyc;
      P = 6 + int'($urandom % 15);
      L = 3 + int'($urandom % 5);
      HW = 1 + int'($urandom % P);
      VW = 1 + int'($urandom % L);
      HO = int'($urandom % P);
      VO = int'($urandom % L);
      cfg_hpol = 1'($urandom); cfg_vpol = 1'($urandom); cfg_fpol = 1'($urandom);
      apply_cfg(0, 1'($urandom), 1'($urandom));
      do_reset();
      cyc = 3 * (P + 1) * (L + 1) + 3;
      for (int n = 1; n <= cyc; n++) begin
        int xp, xl, xf;
        hs_i = 1'($urandom); vs_i = 1'($urandom); fs_i = 1'($urandom);
        vid_data = (n % 7 == 0) ? 8'hFF : 8'($urandom);
        step(1);
        xp = n % (P + 1);
        xl = (n / (P + 1)) % (L + 1);
        xf = (n / ((P + 1) * (L + 1))) % 2;
        chk("R2 R4 master pix", int'(pix_cnt), xp);
        chk("R2 R4 master line", int'(line_cnt), xl);
        chk("R3 R4 master field", int'(field_id), xf);
        chk("R3 hs_o", int'(hs_o), lvl(xp < HW, cfg_hpol));
        chk("R3 vs_o", int'(vs_o), lvl(xl < VW, cfg_vpol));
        chk("R3 fs_o", int'(fs_o), lvl(xl < VW && xf == 0, cfg_fpol));
        chk("R9 master oe", int'({hs_oe, vs_oe, fs_oe}), 7);
      end
    end

    // sync-pin slave mode
    for (int it = 0; it < 4; it++) begin
      P = 10 + int'($urandom % 10);
      L = 4 + int'($urandom % 4);
      HW = 2; VW = 1;
      HO = int'($urandom % (P - 4));
      VO = int'($urandom % (L + 1));
      cfg_hpol = 1'($urandom); cfg_vpol = 1'($urandom); cfg_fpol = 1'($urandom);
      apply_cfg((it == 3) ? 3 : 1, 1'b0, 1'b0);
      do_reset();
      run(4 + int'($urandom % 6), "R2 slave free run");
      chk("R9 pin mode hs_oe", int'(hs_oe), 0);
      chk("R9 pin mode fs_oe", int'(fs_oe), 0);

      hs_i = cfg_hpol;
      evt(1'b1, 1'b0, "R5 hs edge");
      run(3, "R5 hs held");
      hs_i = ~cfg_hpol;
      run(3, "R5 hs release");

      vs_i = cfg_vpol;
      evt(1'b0, 1'b1, "R6 vs edge");
      run(2, "R6 vs held");
      vs_i = ~cfg_vpol;
      run(2, "R6 vs release");

      fs_i = cfg_fpol;
      evt(1'b0, 1'b0, "R7 fs not selected");
      chk("R8 field follows fs", int'(field_id), 1);
      fs_i = ~cfg_fpol;
      run(2, "R7 fs release");
      chk("R8 field clears", int'(field_id), 0);

      cfg_h_from_fs = 1'b1;
      cfg_v_from_fs = 1'b1;
      step(1); el = nl(ep, el); ep = np(ep);
      chk("R9 both from fs hs_oe", int'(hs_oe), 1);
      chk("R9 both from fs vs_oe", int'(vs_oe), 1);
      chk("R9 both from fs fs_oe", int'(fs_oe), 0);
      fs_i = cfg_fpol;
      evt(1'b1, 1'b1, "R7 fs both phases");
      chk("R8 field on fs", int'(field_id), 1);
      hs_i = cfg_hpol;
      vs_i = cfg_vpol;
      evt(1'b0, 1'b0, "R7 hs vs ignored");
      hs_i = ~cfg_hpol;
      vs_i = ~cfg_vpol;
      fs_i = ~cfg_fpol;
      run(2, "R7 release");

      cfg_v_from_fs = 1'b0;
      step(1); el = nl(ep, el); ep = np(ep);
      chk("R9 h only hs_oe", int'(hs_oe), 0);
      fs_i = cfg_fpol;
      evt(1'b1, 1'b0, "R7 fs pixel only");
      fs_i = ~cfg_fpol;
      run(2, "R7 fs pixel release");
    end

    // reference-code slave mode
    P = 15; L = 7; HW = 3; VW = 2; HO = 3; VO = 2;
    cfg_hpol = 1'b1; cfg_vpol = 1'b0; cfg_fpol = 1'b1;
    apply_cfg(2, 1'b0, 1'b0);
    do_reset();
    chk("R9 code mode oe", int'({hs_oe, vs_oe, fs_oe}), 7);
    run(4, "R2 code mode free run");
    send_code(1'b0, 1'b1, 1'b1, 0);
    evt(1'b1, 1'b0, "R10 eav in blanking");
    chk("R12 field from eav", int'(field_id), 0);
    send_code(1'b1, 1'b0, 1'b1, 0);
    evt(1'b1, 1'b1, "R12 blanking end");
    chk("R12 field set", int'(field_id), 1);
    send_code(1'b1, 1'b0, 1'b1, 0);
    evt(1'b1, 1'b0, "R12 active repeat");
    send_code(1'b0, 1'b1, 1'b1, 1);
    evt(1'b0, 1'b0, "R11 bad protection");
    chk("R11 field kept", int'(field_id), 1);
    send_code(1'b0, 1'b1, 1'b1, 2);
    evt(1'b0, 1'b0, "R11 top bit clear");
    chk("R11 field kept again", int'(field_id), 1);
    send_code(1'b0, 1'b0, 1'b0, 0);
    evt(1'b0, 1'b0, "R12 sav no load");
    chk("R12 field from sav", int'(field_id), 0);
    run(5, "R2 after codes");
    for (int k = 0; k < 6; k++) begin
      bit rf;
      rf = 1'($urandom);
      send_code(rf, 1'b1, 1'b1, 0);
      evt(1'b1, 1'b0, "R10 random eav");
      send_code(rf, 1'b0, 1'b1, 0);
      evt(1'b1, 1'b1, "R12 random blanking end");
      chk("R12 random field", int'(field_id), int'(rf));
      run(int'($urandom % 20), "R2 random gap");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule